// File: doc/BRIEF.md
# 8-bit ALU with Flag Update

This block is the arithmetic and flag-update datapath of a small 8-bit accumulator processor. It is purely combinational. The surrounding core decodes an instruction and presents an operation code to the block, together with the operands it needs and the current zero (Z), auxiliary carry (AC) and carry (CY) flags. Within the same cycle the block returns a result, a flag that says whether that result is to be written back, the next value of each flag, and a write-enable for each flag.

The operations fall into three groups:
- **Byte operations:** compare, increment, decrement, the four single-bit rotates, and forcing one bit of an operand to 1 or 0.
- **Word operations:** a 16-bit register pair combined with a 16-bit immediate, or stepped by one.
- **Flag operations:** a bit set or clear aimed at the flag word, and set, clear or complement of the carry.

Each group has its own rule for which flags it updates. A flag whose write-enable is low is passed through unchanged on its output, so the core can latch all three flags on every instruction.

Instruction fetch, decoding, address generation and the register file belong to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: Byte compare (op 0) computes opnd_a − opnd_b and does not assert res_we. It writes Z (difference is zero), AC (opnd_a[3:0] < opnd_b[3:0]) and CY (opnd_a < opnd_b, unsigned).
- R2: Word add (op 1) returns pair_in + imm_w modulo 2^16 with res_we high. It writes CY (carry out of bit 15), AC (carry out of bit 3) and Z (16-bit result is zero).
- R3: Word subtract (op 2) returns pair_in − imm_w modulo 2^16 with res_we high. Word compare (op 3) computes the same difference with res_we low. Both write CY (pair_in < imm_w), AC (pair_in[3:0] < imm_w[3:0]) and Z (difference is zero).
- R4: Byte increment (op 4) and byte decrement (op 5) return opnd_a ± 1 modulo 256 in result[7:0], with res_we high. They write Z (result is zero) and AC (carry or borrow across bit 3/bit 4). CY is never written.
- R5: Word increment (op 6) and word decrement (op 7) return pair_in ± 1 modulo 2^16 with res_we high. No flag write-enable is asserted.
- R6: Rotate right (op 8) moves bit m to bit m−1 and bit 0 into both bit 7 and CY. Rotate left (op 9) moves bit m to bit m+1 and bit 7 into both bit 0 and CY. Only CY is written.
- R7: Rotate right through carry (op 10) puts opnd_a[0] into CY and the incoming CY into bit 7. Rotate left through carry (op 11) puts opnd_a[7] into CY and the incoming CY into bit 0. Only CY is written.
- R8: Bit set (op 12) and bit clear (op 13) return opnd_a with bit bit_sel forced to 1 or 0, with res_we high. No flag is written.
- R9: Flag-word bit set (op 14) and flag-word bit clear (op 15) map bit_sel 6 to Z, 4 to AC and 0 to CY, forcing that one flag to 1 or 0. Any other bit_sel writes no flag. No result is written.
- R10: Carry set (op 16), carry clear (op 17) and carry complement (op 18) write only CY: 1, 0, or the inverse of cy_in respectively.
- R11: Op codes 19 to 31 write nothing. Whenever a flag's write-enable is low, that flag's output equals its input. The result is zero whenever res_we is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code (see requirements) |
| opnd_a | input | 8 | Accumulator or byte operand |
| opnd_b | input | 8 | Second byte operand for compare |
| pair_in | input | 16 | Register pair operand |
| imm_w | input | 16 | 16-bit immediate operand |
| bit_sel | input | 3 | Bit index for bit set/clear |
| z_in | input | 1 | Current zero flag |
| ac_in | input | 1 | Current auxiliary carry flag |
| cy_in | input | 1 | Current carry flag |
| result | output | 16 | Result; byte results in bits 7:0, upper byte zero |
| res_we | output | 1 | Result is to be written back |
| z_out | output | 1 | Next zero flag |
| ac_out | output | 1 | Next auxiliary carry flag |
| cy_out | output | 1 | Next carry flag |
| z_we | output | 1 | Zero flag write-enable |
| ac_we | output | 1 | Auxiliary carry write-enable |
| cy_we | output | 1 | Carry write-enable |

## Verification
The bench targets the wrap points, where a wrong design shows itself in specific ways:
- **Byte increment from 0xFF and decrement from 0x00:** a design that leaked the carry into CY would change a flag that has to survive. A design that took Z from a wider sum would miss the zero.
- **Word add of 0xFFFF + 1 and subtract of 0 − 1:** these expose a missing bit-16 carry or an inverted borrow.
- **Low nibbles of 0xF and 0x0:** these separate a correct auxiliary carry from one taken at the wrong bit boundary.
- **Rotates through carry with both values of the incoming carry:** a swapped fill bit shows up here.
- **Flag-word bit operations on indexes that map to no flag:** a design with loose decoding would disturb Z, AC or CY.

Constrained random operands biased toward 0x00, 0x0F, 0xF0 and 0xFF cover all op codes between these directed cases.

// File: rtl/alu8_pkg.sv
// Package: shared widths, flag-word bit positions, operation codes and the
// per-unit output record used by the ALU sub-units and the top.
package alu8_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int NIB_W   = 4;
    localparam int IDX_W   = $clog2(BYTE_W);
    localparam int OP_W    = 5;

    // Position of each flag inside the flag word, used by flag-word bit ops.
    localparam int Z_POS   = 6;
    localparam int AC_POS  = 4;
    localparam int CY_POS  = 0;

    typedef enum logic [OP_W-1:0] {
        OP_CMP   = 5'd0,
        OP_ADDW  = 5'd1,
        OP_SUBW  = 5'd2,
        OP_CMPW  = 5'd3,
        OP_INC   = 5'd4,
        OP_DEC   = 5'd5,
        OP_INCW  = 5'd6,
        OP_DECW  = 5'd7,
        OP_ROR   = 5'd8,
        OP_ROL   = 5'd9,
        OP_RORC  = 5'd10,
        OP_ROLC  = 5'd11,
        OP_BSET  = 5'd12,
        OP_BCLR  = 5'd13,
        OP_FSET  = 5'd14,
        OP_FCLR  = 5'd15,
        OP_CYSET = 5'd16,
        OP_CYCLR = 5'd17,
        OP_CYNOT = 5'd18
    } alu_op_e;

    // Output record of one sub-unit; all zero when the unit does not own the op.
    typedef struct packed {
        logic [WORD_W-1:0] res;
        logic              res_we;
        logic              z;
        logic              ac;
        logic              cy;
        logic              z_we;
        logic              ac_we;
        logic              cy_we;
    } unit_out_t;

endpackage

// File: rtl/alu8_byte_unit.sv
// Byte unit: compare, increment, decrement, rotates and operand bit set/clear.
// Assumes the opcode is decoded by the caller; drives an all-zero record for
// any opcode it does not own so the top can OR the unit records together.
module alu8_byte_unit
    import alu8_pkg::*;
(
    input  alu_op_e               op,
    input  logic [BYTE_W-1:0]     a,
    input  logic [BYTE_W-1:0]     b,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  cy_in,
    output unit_out_t             o
);
    localparam logic [BYTE_W-1:0] ONE_B = BYTE_W'(1);

    logic [BYTE_W-1:0] bit_mask;
    logic [BYTE_W:0]   diff_ext;
    logic [BYTE_W-1:0] r;

    // One-hot mask of the selected bit, one decoder term per bit position.
    for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
        assign bit_mask[i] = (idx == IDX_W'(i));
    end

    // Extended difference used by compare for the borrow out of the top bit.
    assign diff_ext = {1'b0, a} - {1'b0, b};

    // Per-op byte result and flag selection.
    always_comb begin
        o = '0;
        r = '0;
        unique case (op)
            OP_CMP: begin
                o.z  = (diff_ext[BYTE_W-1:0] == '0);
                o.ac = (a[NIB_W-1:0] < b[NIB_W-1:0]);
                o.cy = diff_ext[BYTE_W];
                o.z_we = 1'b1; o.ac_we = 1'b1; o.cy_we = 1'b1;
            end
            OP_INC: begin
                r = a + ONE_B;
                o.res_we = 1'b1;
                o.z  = (r == '0);
                o.ac = &a[NIB_W-1:0];
                o.z_we = 1'b1; o.ac_we = 1'b1;
            end
            OP_DEC: begin
                r = a - ONE_B;
                o.res_we = 1'b1;
                o.z  = (r == '0);
                o.ac = ~|a[NIB_W-1:0];
                o.z_we = 1'b1; o.ac_we = 1'b1;
            end
            OP_ROR: begin
                r = {a[0], a[BYTE_W-1:1]};
                o.res_we = 1'b1; o.cy = a[0]; o.cy_we = 1'b1;
            end
            OP_ROL: begin
                r = {a[BYTE_W-2:0], a[BYTE_W-1]};
                o.res_we = 1'b1; o.cy = a[BYTE_W-1]; o.cy_we = 1'b1;
            end
            OP_RORC: begin
                r = {cy_in, a[BYTE_W-1:1]};
                o.res_we = 1'b1; o.cy = a[0]; o.cy_we = 1'b1;
            end
            OP_ROLC: begin
                r = {a[BYTE_W-2:0], cy_in};
                o.res_we = 1'b1; o.cy = a[BYTE_W-1]; o.cy_we = 1'b1;
            end
            OP_BSET: begin
                r = a | bit_mask;
                o.res_we = 1'b1;
            end
            OP_BCLR: begin
                r = a & ~bit_mask;
                o.res_we = 1'b1;
            end
            default: ;
        endcase
        o.res = {{(WORD_W-BYTE_W){1'b0}}, r};
    end

endmodule

// File: rtl/alu8_word_unit.sv
// Word unit: 16-bit add, subtract, compare against an immediate, and register
// pair increment/decrement. AC is taken at the nibble boundary of the low byte.
// Drives an all-zero record for opcodes it does not own.
module alu8_word_unit
    import alu8_pkg::*;
(
    input  alu_op_e               op,
    input  logic [WORD_W-1:0]     pair,
    input  logic [WORD_W-1:0]     imm,
    output unit_out_t             o
);
    localparam logic [WORD_W-1:0] ONE_W = WORD_W'(1);

    logic [WORD_W:0]  sum_ext;
    logic [WORD_W:0]  dif_ext;
    logic [NIB_W:0]   nib_sum;
    logic             nib_borrow;

    // Full-width sum and difference with the carry/borrow bit on top.
    assign sum_ext    = {1'b0, pair} + {1'b0, imm};
    assign dif_ext    = {1'b0, pair} - {1'b0, imm};
    assign nib_sum    = {1'b0, pair[NIB_W-1:0]} + {1'b0, imm[NIB_W-1:0]};
    assign nib_borrow = (pair[NIB_W-1:0] < imm[NIB_W-1:0]);

    // Per-op word result and flag selection.
    always_comb begin
        o = '0;
        unique case (op)
            OP_ADDW: begin
                o.res = sum_ext[WORD_W-1:0];
                o.res_we = 1'b1;
                o.z  = (sum_ext[WORD_W-1:0] == '0);
                o.ac = nib_sum[NIB_W];
                o.cy = sum_ext[WORD_W];
                o.z_we = 1'b1; o.ac_we = 1'b1; o.cy_we = 1'b1;
            end
            OP_SUBW, OP_CMPW: begin
                o.res    = (op == OP_SUBW) ? dif_ext[WORD_W-1:0] : '0;
                o.res_we = (op == OP_SUBW);
                o.z  = (dif_ext[WORD_W-1:0] == '0);
                o.ac = nib_borrow;
                o.cy = dif_ext[WORD_W];
                o.z_we = 1'b1; o.ac_we = 1'b1; o.cy_we = 1'b1;
            end
            OP_INCW: begin
                o.res = pair + ONE_W;
                o.res_we = 1'b1;
            end
            OP_DECW: begin
                o.res = pair - ONE_W;
                o.res_we = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_flag_unit.sv
// Flag unit: bit set/clear aimed at the flag word and the dedicated carry
// operations. Only indexes that map onto Z, AC or CY raise a write-enable.
// Produces no result; drives an all-zero record for opcodes it does not own.
module alu8_flag_unit
    import alu8_pkg::*;
(
    input  alu_op_e               op,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  cy_in,
    output unit_out_t             o
);
    logic fw_op;
    logic fw_val;

    assign fw_op  = (op == OP_FSET) || (op == OP_FCLR);
    assign fw_val = (op == OP_FSET);

    // Flag-word bit decode and carry set/clear/complement.
    always_comb begin
        o = '0;
        if (fw_op) begin
            o.z  = fw_val; o.z_we  = (idx == IDX_W'(Z_POS));
            o.ac = fw_val; o.ac_we = (idx == IDX_W'(AC_POS));
            o.cy = fw_val; o.cy_we = (idx == IDX_W'(CY_POS));
        end
        unique case (op)
            OP_CYSET: begin o.cy = 1'b1;   o.cy_we = 1'b1; end
            OP_CYCLR: begin o.cy = 1'b0;   o.cy_we = 1'b1; end
            OP_CYNOT: begin o.cy = ~cy_in; o.cy_we = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
// Top: combinational 8-bit ALU with flag update. Routes operands to the byte,
// word and flag units, merges their records (each unit is zero outside its
// own opcodes) and passes a flag through unchanged when it is not written.
// Assumes op_sel is stable for the evaluation; no state is held here.
module alu8_core
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]   op_sel,
    input  logic [BYTE_W-1:0] opnd_a,
    input  logic [BYTE_W-1:0] opnd_b,
    input  logic [WORD_W-1:0] pair_in,
    input  logic [WORD_W-1:0] imm_w,
    input  logic [IDX_W-1:0]  bit_sel,
    input  logic              z_in,
    input  logic              ac_in,
    input  logic              cy_in,
    output logic [WORD_W-1:0] result,
    output logic              res_we,
    output logic              z_out,
    output logic              ac_out,
    output logic              cy_out,
    output logic              z_we,
    output logic              ac_we,
    output logic              cy_we
);
    alu_op_e   op;
    unit_out_t byte_o, word_o, flag_o, merged;

    assign op = alu_op_e'(op_sel);

    alu8_byte_unit u_byte (
        .op    (op),
        .a     (opnd_a),
        .b     (opnd_b),
        .idx   (bit_sel),
        .cy_in (cy_in),
        .o     (byte_o)
    );

    alu8_word_unit u_word (
        .op    (op),
        .pair  (pair_in),
        .imm   (imm_w),
        .o     (word_o)
    );

    alu8_flag_unit u_flag (
        .op    (op),
        .idx   (bit_sel),
        .cy_in (cy_in),
        .o     (flag_o)
    );

    // Merge of the unit records; at most one unit is active per opcode.
    assign merged = byte_o | word_o | flag_o;

    // Output drive with pass-through of unwritten flags.
    always_comb begin
        result = merged.res;
        res_we = merged.res_we;
        z_we   = merged.z_we;
        ac_we  = merged.ac_we;
        cy_we  = merged.cy_we;
        z_out  = merged.z_we  ? merged.z  : z_in;
        ac_out = merged.ac_we ? merged.ac : ac_in;
        cy_out = merged.cy_we ? merged.cy : cy_in;
    end

endmodule

// File: rtl/alu8_core_chk.sv
// Checker: immediate assertions on the port behaviour of alu8_core, bound to
// every instance. The block is combinational, so checks run on settled values.
module alu8_core_chk
    import alu8_pkg::*;
(
    input  logic [OP_W-1:0]   op_sel,
    input  logic [BYTE_W-1:0] opnd_a,
    input  logic              z_in,
    input  logic              ac_in,
    input  logic              cy_in,
    input  logic [WORD_W-1:0] result,
    input  logic              res_we,
    input  logic              z_out,
    input  logic              ac_out,
    input  logic              cy_out,
    input  logic              z_we,
    input  logic              ac_we,
    input  logic              cy_we
);
    // Flag-enable policy per operation class and pass-through rules.
    always_comb begin
        if (!$isunknown(op_sel)) begin
            if (op_sel == 5'd0 || op_sel == 5'd3) begin
                assert_compare_no_write_R1: assert (!res_we)
                    else $error("compare wrote a result");
            end
            if (op_sel == 5'd4 || op_sel == 5'd5) begin
                assert_byte_step_keeps_cy_R4: assert (!cy_we && z_we && ac_we)
                    else $error("byte step flag enables wrong");
            end
            if (op_sel == 5'd6 || op_sel == 5'd7) begin
                assert_word_step_keeps_flags_R5: assert (!z_we && !ac_we && !cy_we)
                    else $error("word step wrote a flag");
            end
            if (op_sel >= 5'd8 && op_sel <= 5'd11) begin
                assert_rotate_only_cy_R6: assert (cy_we && !z_we && !ac_we)
                    else $error("rotate flag enables wrong");
            end
            if (op_sel == 5'd16) begin
                assert_carry_set_R10: assert (cy_we && cy_out)
                    else $error("carry set failed");
            end
            if (op_sel >= 5'd19) begin
                assert_idle_op_R11: assert (!res_we && !z_we && !ac_we && !cy_we)
                    else $error("idle op wrote something");
            end
            if (!z_we && !$isunknown(z_in)) begin
                assert_z_pass_R11: assert (z_out == z_in) else $error("Z not held");
            end
            if (!ac_we && !$isunknown(ac_in)) begin
                assert_ac_pass_R11: assert (ac_out == ac_in) else $error("AC not held");
            end
            if (!cy_we && !$isunknown(cy_in)) begin
                assert_cy_pass_R11: assert (cy_out == cy_in) else $error("CY not held");
            end
            if (op_sel == 5'd8 && !$isunknown(opnd_a)) begin
                assert_ror_cy_R6: assert (cy_out == opnd_a[0] && result[BYTE_W-1] == opnd_a[0])
                    else $error("rotate right bit 0 not copied");
            end
        end
    end
endmodule

bind alu8_core alu8_core_chk chk_i (
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .z_in   (z_in),
    .ac_in  (ac_in),
    .cy_in  (cy_in),
    .result (result),
    .res_we (res_we),
    .z_out  (z_out),
    .ac_out (ac_out),
    .cy_out (cy_out),
    .z_we   (z_we),
    .ac_we  (ac_we),
    .cy_we  (cy_we)
);

// File: tb/alu8_core_tb_top.sv
// Bench: directed corners plus seeded random stimulus, compared against an
// independent reference model written from the requirements.
module alu8_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_sel;
    logic [7:0]  opnd_a, opnd_b;
    logic [15:0] pair_in, imm_w;
    logic [2:0]  bit_sel;
    logic        z_in, ac_in, cy_in;
    logic [15:0] result;
    logic        res_we, z_out, ac_out, cy_out, z_we, ac_we, cy_we;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    alu8_core dut_i (
        .op_sel (op_sel), .opnd_a (opnd_a), .opnd_b (opnd_b),
        .pair_in (pair_in), .imm_w (imm_w), .bit_sel (bit_sel),
        .z_in (z_in), .ac_in (ac_in), .cy_in (cy_in),
        .result (result), .res_we (res_we),
        .z_out (z_out), .ac_out (ac_out), .cy_out (cy_out),
        .z_we (z_we), .ac_we (ac_we), .cy_we (cy_we)
    );

    function automatic string req_of(input int op);
        case (op)
            0:         return "R1";
            1:         return "R2";
            2, 3:      return "R3";
            4, 5:      return "R4";
            6, 7:      return "R5";
            8, 9:      return "R6";
            10, 11:    return "R7";
            12, 13:    return "R8";
            14, 15:    return "R9";
            16, 17, 18: return "R10";
            default:   return "R11";
        endcase
    endfunction

    // Reference model: {res_we, result, we[2:0]={z,ac,cy}, val[2:0]}
    function automatic void model(input int op, input logic [7:0] a, b,
                                  input logic [15:0] p, w, input logic [2:0] ix,
                                  input logic cyi,
                                  output logic rwe, output logic [15:0] r,
                                  output logic [2:0] we, output logic [2:0] v);
        logic [16:0] t;
        rwe = 0; r = 0; we = 0; v = 0;
        case (op)
            0: begin we = 3'b111; v = {(a == b), (a[3:0] < b[3:0]), (a < b)}; end
            1: begin t = {1'b0,p} + {1'b0,w}; rwe = 1; r = t[15:0]; we = 3'b111;
                     v = {(t[15:0] == 0), ((p[3:0] + w[3:0]) > 15), t[16]}; end
            2, 3: begin rwe = (op == 2); r = (op == 2) ? p - w : 16'h0; we = 3'b111;
                     v = {(p == w), (p[3:0] < w[3:0]), (p < w)}; end
            4: begin rwe = 1; r = {8'h0, a + 8'd1}; we = 3'b110;
                     v = {(a == 8'hFF), (a[3:0] == 4'hF), 1'b0}; end
            5: begin rwe = 1; r = {8'h0, a - 8'd1}; we = 3'b110;
                     v = {(a == 8'h01), (a[3:0] == 4'h0), 1'b0}; end
            6: begin rwe = 1; r = p + 16'd1; end
            7: begin rwe = 1; r = p - 16'd1; end
            8: begin rwe = 1; r = {8'h0, a[0], a[7:1]}; we = 3'b001; v = {2'b0, a[0]}; end
            9: begin rwe = 1; r = {8'h0, a[6:0], a[7]}; we = 3'b001; v = {2'b0, a[7]}; end
            10: begin rwe = 1; r = {8'h0, cyi, a[7:1]}; we = 3'b001; v = {2'b0, a[0]}; end
            11: begin rwe = 1; r = {8'h0, a[6:0], cyi}; we = 3'b001; v = {2'b0, a[7]}; end
            12: begin rwe = 1; r = {8'h0, a | (8'd1 << ix)}; end
            13: begin rwe = 1; r = {8'h0, a & ~(8'd1 << ix)}; end
            14, 15: begin
                we = {(ix == 3'd6), (ix == 3'd4), (ix == 3'd0)};
                v  = (op == 14) ? 3'b111 : 3'b000;
            end
            16: begin we = 3'b001; v = 3'b001; end
            17: begin we = 3'b001; v = 3'b000; end
            18: begin we = 3'b001; v = {2'b0, ~cyi}; end
            default: ;
        endcase
    endfunction

    task automatic apply(input int op, input logic [7:0] a, b,
                         input logic [15:0] p, w, input logic [2:0] ix,
                         input logic zi, aci, cyi);
        logic rwe; logic [15:0] r; logic [2:0] we, v, ef, gf;
        @(posedge clk);
        op_sel = op[4:0]; opnd_a = a; opnd_b = b; pair_in = p; imm_w = w;
        bit_sel = ix; z_in = zi; ac_in = aci; cy_in = cyi;
        @(negedge clk);
        model(op, a, b, p, w, ix, cyi, rwe, r, we, v);
        ef = {we[2] ? v[2] : zi, we[1] ? v[1] : aci, we[0] ? v[0] : cyi};
        gf = {z_out, ac_out, cy_out};
        n_tests++;
        if (res_we !== rwe || result !== r || {z_we, ac_we, cy_we} !== we || gf !== ef) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h p=%h w=%h ix=%0d: got res=%h we=%b fwe=%b flg=%b, exp res=%h we=%b fwe=%b flg=%b",
                     req_of(op), op, a, b, p, w, ix, result, res_we, {z_we, ac_we, cy_we}, gf,
                     r, rwe, we, ef);
        end
    endtask

    function automatic logic [7:0] pick8();
        case ($urandom_range(0, 5))
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h0F;
            3: return 8'hF0;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5EED_1234));
        op_sel = 5'd31; opnd_a = 0; opnd_b = 0; pair_in = 0; imm_w = 0;
        bit_sel = 0; z_in = 0; ac_in = 0; cy_in = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset/idle state: unassigned op writes nothing (R11)
        apply(31, 8'h00, 8'h00, 16'h0, 16'h0, 3'd0, 1'b0, 1'b0, 1'b0);
        apply(19, 8'h5A, 8'h00, 16'h1, 16'h1, 3'd0, 1'b1, 1'b0, 1'b1);
        // R1 compare equal, less, nibble borrow
        apply(0, 8'h42, 8'h42, 0, 0, 0, 0, 1, 1);
        apply(0, 8'h10, 8'h01, 0, 0, 0, 1, 0, 1);
        apply(0, 8'h01, 8'h80, 0, 0, 0, 1, 1, 0);
        // R2 word add wrap to zero, nibble carry
        apply(1, 0, 0, 16'hFFFF, 16'h0001, 0, 0, 0, 0);
        apply(1, 0, 0, 16'h0008, 16'h0008, 0, 1, 0, 1);
        // R3 subtract below zero, compare equal
        apply(2, 0, 0, 16'h0000, 16'h0001, 0, 0, 0, 0);
        apply(3, 0, 0, 16'h1234, 16'h1234, 0, 0, 1, 1);
        // R4 byte step wrap and nibble edge, CY held
        apply(4, 8'hFF, 0, 0, 0, 0, 0, 0, 1);
        apply(4, 8'h0F, 0, 0, 0, 0, 1, 0, 0);
        apply(5, 8'h00, 0, 0, 0, 0, 0, 0, 1);
        apply(5, 8'h01, 0, 0, 0, 0, 0, 1, 0);
        // R5 word step wrap, flags held
        apply(6, 0, 0, 16'hFFFF, 0, 0, 1, 1, 0);
        apply(7, 0, 0, 16'h0000, 0, 0, 0, 1, 1);
        // R6 / R7 rotates with both carry values
        apply(8, 8'h01, 0, 0, 0, 0, 1, 1, 0);
        apply(9, 8'h80, 0, 0, 0, 0, 0, 0, 0);
        apply(10, 8'h02, 0, 0, 0, 0, 0, 0, 1);
        apply(10, 8'h03, 0, 0, 0, 0, 0, 0, 0);
        apply(11, 8'h80, 0, 0, 0, 0, 0, 0, 1);
        apply(11, 8'h7F, 0, 0, 0, 0, 0, 0, 0);
        // R8 bit set / clear at both ends
        apply(12, 8'h00, 0, 0, 0, 3'd7, 1, 0, 1);
        apply(13, 8'hFF, 0, 0, 0, 3'd0, 0, 1, 0);
        // R9 flag-word bits: mapped and unmapped indexes
        for (int i = 0; i < 8; i++) begin
            apply(14, 0, 0, 0, 0, 3'(i), 0, 0, 0);
            apply(15, 0, 0, 0, 0, 3'(i), 1, 1, 1);
        end
        // R10 carry ops
        apply(16, 0, 0, 0, 0, 0, 1, 1, 0);
        apply(17, 0, 0, 0, 0, 0, 0, 0, 1);
        apply(18, 0, 0, 0, 0, 0, 0, 0, 1);
        apply(18, 0, 0, 0, 0, 0, 0, 0, 0);
        // Random mix over all op codes
        for (int k = 0; k < 4000; k++) begin
            logic [7:0] a = pick8();
            logic [7:0] b = pick8();
            apply($urandom_range(0, 31), a, b, {pick8(), pick8()}, {pick8(), pick8()},
                  3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule